// File: doc/BRIEF.md
# IO Address Translation Cache

This block keeps recently completed IO virtual-to-physical page translations so that repeated device accesses skip the page-table walk. Every entry is tagged with two context identifiers: a guest soft-context ID (taken from the device context's second-stage pointer) and a process soft-context ID (taken from the device context's translation attributes). A lookup presents an IO virtual address and both IDs. One cycle later the block returns a hit flag, the physical address and the cached read/write permissions. On a miss, the request goes to an external walker, which is outside this block.

The walker's result comes back on a fill port. The cache stores it only when the result is worth keeping. A runtime limit sets how many entries may be live. When a fill arrives with the cache already at that limit, the whole contents are discarded and the new entry is written. An invalidate port clears the permissions of matching entries. It can match all entries, one guest context, one guest and process pair, or one exact page. Pages are 4 KiB, so the page number is address bits [55:12]. Storage is a fully associative array of 16 entries.

Top module: `iotc_top`

## Requirements
- R1: After reset the cache holds no entries, so every lookup misses.
- R2: A lookup with `lk_valid` high produces `rsp_valid` high on the next cycle, and `rsp_valid` is low otherwise. A hit requires the guest ID, the process ID and the page number (address bits [55:12]) all to equal a stored entry's tag, and that entry's permission field to be nonzero. Permission code 0 means no access.
- R3: On a hit, `rsp_paddr` equals the cached physical page number in bits [55:12] and the request's page offset in bits [11:0]. `rsp_perm` equals the cached 2-bit permission field.
- R4: A fill is stored only when all of the following hold: `fl_valid`, `cfg_enable` and `fl_cache_en` are high, `fl_fault` and `fl_msi_trap` are low, and `fl_paddr` differs from `fl_iova`. A rejected fill changes nothing that a lookup can see.
- R5: While the effective limit is zero, no fill is stored and the entry count does not change.
- R6: The effective limit is `min(cfg_limit, 16)`. A fill that is accepted while the entry count is at or above the effective limit first discards every entry, then stores the new entry as the only one.
- R7: An accepted fill whose tag equals a stored entry's tag overwrites that entry in place and does not increase the entry count.
- R8: Invalidate modes (`inv_mode`) are: 0 matches all entries, 1 matches the guest ID, 2 matches the guest and process IDs, 3 matches the guest ID, the process ID and the page number. Matching entries get permission 0. Each such entry keeps its slot and still counts toward the limit.
- R9: When a lookup and an invalidate occur in the same cycle, the invalidate takes effect first. When a lookup and a fill occur in the same cycle, the lookup sees the contents before the fill.
- R10: While `cfg_enable` is low, every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_enable | input | 1 | Global cache enable |
| cfg_limit | input | 5 | Runtime capacity limit |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 56 | IO virtual address to translate |
| lk_gscid | input | 16 | Guest soft-context ID of the request |
| lk_pscid | input | 20 | Process soft-context ID of the request |
| rsp_valid | output | 1 | Lookup response valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_paddr | output | 56 | Translated physical address on hit, else zero |
| rsp_perm | output | 2 | Cached permissions on hit, else zero |
| fl_valid | input | 1 | Walk result present |
| fl_iova | input | 56 | IO virtual address of the walk |
| fl_paddr | input | 56 | Translated address from the walk |
| fl_gscid | input | 16 | Guest ID of the walk |
| fl_pscid | input | 20 | Process ID of the walk |
| fl_perm | input | 2 | Permissions from the walk |
| fl_fault | input | 1 | Walk reported a fault |
| fl_msi_trap | input | 1 | Result was redirected to the MSI trap target |
| fl_cache_en | input | 1 | Caching allowed for this request |
| inv_valid | input | 1 | Invalidate request |
| inv_mode | input | 2 | Invalidate match mode |
| inv_gscid | input | 16 | Guest ID to match |
| inv_pscid | input | 20 | Process ID to match |
| inv_vpn | input | 44 | Page number to match |

## Verification
A lookup can fall in the same cycle as an invalidate, and also in the same cycle as a fill. The bench drives a lookup together with an exact-page invalidate of the same key. It then drives random traffic in which lookups, fills and invalidates over a small key space overlap often. Each cycle is judged against a reference model held in an associative array. The model applies the invalidate first, answers the lookup next, and applies the fill last.

// File: rtl/iotc_pkg.sv
package iotc_pkg;
    localparam int ADDR_W = 56;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = ADDR_W - OFF_W;
    localparam int PPN_W  = ADDR_W - OFF_W;
    localparam int GS_W   = 16;
    localparam int PS_W   = 20;
    localparam int PERM_W = 2;

    typedef enum logic [1:0] {
        MATCH_ALL   = 2'd0,
        MATCH_GS    = 2'd1,
        MATCH_GS_PS = 2'd2,
        MATCH_EXACT = 2'd3
    } match_mode_e;

    typedef struct packed {
        logic [VPN_W-1:0]  vpn;
        logic [PS_W-1:0]   ps;
        logic [PPN_W-1:0]  ppn;
        logic [GS_W-1:0]   gs;
        logic [PERM_W-1:0] perm;
    } entry_t;
endpackage

// File: rtl/iotc_tag_cmp.sv
module iotc_tag_cmp
    import iotc_pkg::*;
#(
    parameter int N = 16
) (
    input  entry_t [N-1:0]   ents,
    input  match_mode_e      mode,
    input  logic [GS_W-1:0]  gs,
    input  logic [PS_W-1:0]  ps,
    input  logic [VPN_W-1:0] vpn,
    output logic [N-1:0]     match
);
    for (genvar i = 0; i < N; i++) begin : g_ent
        logic m_gs, m_ps, m_vpn;
        assign m_gs  = (ents[i].gs == gs);
        assign m_ps  = (ents[i].ps == ps);
        assign m_vpn = (ents[i].vpn == vpn);
        // nested mode widening: each looser mode drops one tag field
        assign match[i] = (mode == MATCH_ALL) |
                          (m_gs & ((mode == MATCH_GS) |
                          (m_ps & ((mode == MATCH_GS_PS) | m_vpn))));
    end
endmodule

// File: rtl/iotc_fill_gate.sv
module iotc_fill_gate #(
    parameter int AW = 56,
    parameter int CW = 5
) (
    input  logic          fl_valid,
    input  logic          enable,
    input  logic          cache_en,
    input  logic          fault,
    input  logic          msi_trap,
    input  logic [AW-1:0] iova,
    input  logic [AW-1:0] paddr,
    input  logic [CW-1:0] eff_lim,
    output logic          accept
);
    logic identity;
    assign identity = (iova == paddr);
    assign accept   = fl_valid & enable & cache_en & ~fault & ~msi_trap &
                      ~identity & (eff_lim != '0);
endmodule

// File: rtl/iotc_top.sv
module iotc_top
    import iotc_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int CW = $clog2(ENTRIES + 1),
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic [CW-1:0]     cfg_limit,
    input  logic              lk_valid,
    input  logic [ADDR_W-1:0] lk_addr,
    input  logic [GS_W-1:0]   lk_gscid,
    input  logic [PS_W-1:0]   lk_pscid,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [ADDR_W-1:0] rsp_paddr,
    output logic [PERM_W-1:0] rsp_perm,
    input  logic              fl_valid,
    input  logic [ADDR_W-1:0] fl_iova,
    input  logic [ADDR_W-1:0] fl_paddr,
    input  logic [GS_W-1:0]   fl_gscid,
    input  logic [PS_W-1:0]   fl_pscid,
    input  logic [PERM_W-1:0] fl_perm,
    input  logic              fl_fault,
    input  logic              fl_msi_trap,
    input  logic              fl_cache_en,
    input  logic              inv_valid,
    input  logic [1:0]        inv_mode,
    input  logic [GS_W-1:0]   inv_gscid,
    input  logic [PS_W-1:0]   inv_pscid,
    input  logic [VPN_W-1:0]  inv_vpn
);
    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic [CW-1:0]        occ;
        logic                 rv;
        logic                 hit;
        logic [ADDR_W-1:0]    pa;
        logic [PERM_W-1:0]    perm;
    } state_t;

    state_t st_d, st_q;

    logic [CW-1:0]      eff_lim;
    logic               fill_ok;
    logic [ENTRIES-1:0] live, inv_m, lk_m, fl_m;
    logic [PERM_W-1:0]  post_perm [ENTRIES];
    logic [CW-1:0]      occ_q;
    entry_t             new_ent;

    assign occ_q   = st_q.occ;
    assign eff_lim = (cfg_limit > CW'(ENTRIES)) ? CW'(ENTRIES) : cfg_limit;

    iotc_tag_cmp #(.N(ENTRIES)) u_inv_cmp (
        .ents(st_q.ent), .mode(match_mode_e'(inv_mode)),
        .gs(inv_gscid), .ps(inv_pscid), .vpn(inv_vpn), .match(inv_m)
    );
    iotc_tag_cmp #(.N(ENTRIES)) u_lk_cmp (
        .ents(st_q.ent), .mode(MATCH_EXACT),
        .gs(lk_gscid), .ps(lk_pscid), .vpn(lk_addr[ADDR_W-1:OFF_W]), .match(lk_m)
    );
    iotc_tag_cmp #(.N(ENTRIES)) u_fl_cmp (
        .ents(st_q.ent), .mode(MATCH_EXACT),
        .gs(fl_gscid), .ps(fl_pscid), .vpn(fl_iova[ADDR_W-1:OFF_W]), .match(fl_m)
    );
    iotc_fill_gate #(.AW(ADDR_W), .CW(CW)) u_gate (
        .fl_valid(fl_valid), .enable(cfg_enable), .cache_en(fl_cache_en),
        .fault(fl_fault), .msi_trap(fl_msi_trap), .iova(fl_iova),
        .paddr(fl_paddr), .eff_lim(eff_lim), .accept(fill_ok)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_live
        assign live[i]      = (CW'(i) < st_q.occ);
        // invalidate is applied ahead of the lookup in the same cycle
        assign post_perm[i] = (inv_valid && inv_m[i]) ? '0 : st_q.ent[i].perm;
    end

    assign new_ent = '{vpn:  fl_iova[ADDR_W-1:OFF_W],
                       ps:   fl_pscid,
                       ppn:  fl_paddr[ADDR_W-1:OFF_W],
                       gs:   fl_gscid,
                       perm: fl_perm};

    always_comb begin
        logic          dup_any;
        logic [IW-1:0] dup_idx;
        st_d      = st_q;
        st_d.rv   = lk_valid;
        st_d.hit  = 1'b0;
        st_d.pa   = '0;
        st_d.perm = '0;
        dup_any   = 1'b0;
        dup_idx   = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            st_d.ent[i].perm = post_perm[i];
            if (lk_valid && cfg_enable && live[i] && lk_m[i] && post_perm[i] != '0) begin
                st_d.hit  = 1'b1;
                st_d.pa   = {st_q.ent[i].ppn, lk_addr[OFF_W-1:0]};
                st_d.perm = post_perm[i];
            end
            if (live[i] && fl_m[i]) begin
                dup_any = 1'b1;
                dup_idx = IW'(i);
            end
        end
        if (fill_ok) begin
            if (st_q.occ >= eff_lim) begin
                st_d.ent[0] = new_ent;
                st_d.occ    = CW'(1);
            end else if (dup_any) begin
                st_d.ent[dup_idx] = new_ent;
            end else begin
                st_d.ent[st_q.occ[IW-1:0]] = new_ent;
                st_d.occ                   = st_q.occ + CW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid = st_q.rv;
    assign rsp_hit   = st_q.hit;
    assign rsp_paddr = st_q.pa;
    assign rsp_perm  = st_q.perm;
endmodule

// File: rtl/iotc_chk.sv
module iotc_chk #(
    parameter int ENTRIES = 16,
    localparam int CW = $clog2(ENTRIES + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cfg_enable,
    input logic [CW-1:0] cfg_limit,
    input logic          lk_valid,
    input logic          fl_valid,
    input logic          fl_fault,
    input logic          rsp_valid,
    input logic          rsp_hit,
    input logic [1:0]    rsp_perm,
    input logic [CW-1:0] occ
);
    a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);
    a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rsp_valid);
    a_r2_hit_has_perm: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (rsp_valid && rsp_perm != 2'd0));
    a_r10_disabled_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && !cfg_enable) |=> !rsp_hit);
    a_r4_fault_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && fl_fault) |=> occ == $past(occ));
    a_r5_zero_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_limit == '0) |=> occ == $past(occ));
    a_r8_inval_keeps_slots: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_valid |=> occ == $past(occ));
    a_r6_occ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(ENTRIES));
endmodule

bind iotc_top iotc_chk #(.ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_limit(cfg_limit),
    .lk_valid(lk_valid), .fl_valid(fl_valid), .fl_fault(fl_fault),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_perm(rsp_perm), .occ(occ_q)
);

// File: tb/sim_iotc_top.sv
`timescale 1ns/1ps
module sim_iotc_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1;
    logic [4:0]  cfg_limit = 5'd16;
    logic        lk_valid = 1'b0;
    logic [55:0] lk_addr = '0;
    logic [15:0] lk_gscid = '0;
    logic [19:0] lk_pscid = '0;
    logic        rsp_valid, rsp_hit;
    logic [55:0] rsp_paddr;
    logic [1:0]  rsp_perm;
    logic        fl_valid = 1'b0;
    logic [55:0] fl_iova = '0, fl_paddr = '0;
    logic [15:0] fl_gscid = '0;
    logic [19:0] fl_pscid = '0;
    logic [1:0]  fl_perm = '0;
    logic        fl_fault = 1'b0, fl_msi_trap = 1'b0, fl_cache_en = 1'b1;
    logic        inv_valid = 1'b0;
    logic [1:0]  inv_mode = '0;
    logic [15:0] inv_gscid = '0;
    logic [19:0] inv_pscid = '0;
    logic [43:0] inv_vpn = '0;

    int n_total = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    iotc_top u0 (.*);

    // reference model: key {gscid, pscid, vpn} -> {ppn, perm}
    logic [45:0] mdl [logic [79:0]];

    function automatic logic [79:0] mk(logic [15:0] g, logic [19:0] p, logic [43:0] v);
        return {g, p, v};
    endfunction

    function automatic int lim_eff();
        return (cfg_limit > 5'd16) ? 16 : int'(cfg_limit);
    endfunction

    task automatic idle();
        lk_valid = 1'b0; fl_valid = 1'b0; inv_valid = 1'b0;
        fl_fault = 1'b0; fl_msi_trap = 1'b0; fl_cache_en = 1'b1;
    endtask

    task automatic set_lk(logic [15:0] g, logic [19:0] p, logic [43:0] v, logic [11:0] off);
        lk_valid = 1'b1; lk_gscid = g; lk_pscid = p; lk_addr = {v, off};
    endtask

    task automatic set_fill(logic [15:0] g, logic [19:0] p, logic [43:0] v,
                            logic [43:0] ppn, logic [1:0] perm);
        fl_valid = 1'b1; fl_gscid = g; fl_pscid = p; fl_perm = perm;
        fl_iova = {v, 12'h000}; fl_paddr = {ppn, 12'h000};
    endtask

    task automatic set_inv(logic [1:0] m, logic [15:0] g, logic [19:0] p, logic [43:0] v);
        inv_valid = 1'b1; inv_mode = m; inv_gscid = g; inv_pscid = p; inv_vpn = v;
    endtask

    // one cycle: model (invalidate, then lookup, then fill), clock edge, compare
    task automatic go(string tag);
        logic        e_v, e_h;
        logic [55:0] e_pa;
        logic [1:0]  e_perm;
        logic [79:0] k;
        if (inv_valid) begin
            foreach (mdl[kk]) begin
                logic hitm;
                case (inv_mode)
                    2'd0:    hitm = 1'b1;
                    2'd1:    hitm = (kk[79:64] == inv_gscid);
                    2'd2:    hitm = (kk[79:64] == inv_gscid) && (kk[63:44] == inv_pscid);
                    default: hitm = (kk[79:64] == inv_gscid) && (kk[63:44] == inv_pscid) &&
                                    (kk[43:0] == inv_vpn);
                endcase
                if (hitm) mdl[kk][1:0] = 2'd0;
            end
        end
        e_v = lk_valid; e_h = 1'b0; e_pa = '0; e_perm = '0;
        k = mk(lk_gscid, lk_pscid, lk_addr[55:12]);
        if (lk_valid && cfg_enable && mdl.exists(k) && mdl[k][1:0] != 2'd0) begin
            e_h = 1'b1; e_pa = {mdl[k][45:2], lk_addr[11:0]}; e_perm = mdl[k][1:0];
        end
        if (fl_valid && cfg_enable && fl_cache_en && !fl_fault && !fl_msi_trap &&
            fl_iova != fl_paddr && lim_eff() != 0) begin
            if (mdl.num() >= lim_eff()) mdl.delete();
            mdl[mk(fl_gscid, fl_pscid, fl_iova[55:12])] = {fl_paddr[55:12], fl_perm};
        end
        @(posedge clk);
        #2;
        n_total++;
        if (rsp_valid !== e_v || rsp_hit !== e_h ||
            (e_h && (rsp_paddr !== e_pa || rsp_perm !== e_perm))) begin
            n_fail++;
            $display("FAIL %s: got v=%0b h=%0b pa=%h perm=%0d, expected v=%0b h=%0b pa=%h perm=%0d",
                     tag, rsp_valid, rsp_hit, rsp_paddr, rsp_perm, e_v, e_h, e_pa, e_perm);
        end
        @(negedge clk);
        idle();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_total++; n_fail++;
        $display("FAIL all: watchdog expired");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin : stim
        process::self().srandom(32'd7391);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: empty after reset
        set_lk(16'd1, 20'd1, 44'h10, 12'h123); go("R1 miss after reset");
        // R2/R3: fill then hit with offset kept
        set_fill(16'd1, 20'd1, 44'h10, 44'h777, 2'd3); go("R4 accepted fill");
        set_lk(16'd1, 20'd1, 44'h10, 12'hABC); go("R3 hit address and perm");
        set_lk(16'd1, 20'd2, 44'h10, 12'h000); go("R2 pscid mismatch misses");
        set_lk(16'd2, 20'd1, 44'h10, 12'h000); go("R2 gscid mismatch misses");
        // R4: rejected fills
        set_fill(16'd1, 20'd1, 44'h20, 44'h20, 2'd3); go("R4 identity fill");
        set_lk(16'd1, 20'd1, 44'h20, 12'h0); go("R4 identity not cached");
        set_fill(16'd1, 20'd1, 44'h21, 44'h55, 2'd1); fl_fault = 1'b1; go("R4 fault fill");
        set_fill(16'd1, 20'd1, 44'h22, 44'h56, 2'd1); fl_msi_trap = 1'b1; go("R4 trap fill");
        set_fill(16'd1, 20'd1, 44'h23, 44'h57, 2'd1); fl_cache_en = 1'b0; go("R4 uncached fill");
        set_lk(16'd1, 20'd1, 44'h21, 12'h0); go("R4 fault not cached");
        set_lk(16'd1, 20'd1, 44'h22, 12'h0); go("R4 trap not cached");
        set_lk(16'd1, 20'd1, 44'h23, 12'h0); go("R4 disabled request not cached");
        // R9: lookup and invalidate in one cycle
        set_lk(16'd1, 20'd1, 44'h10, 12'h5); set_inv(2'd3, 16'd1, 20'd1, 44'h10);
        go("R9 invalidate before lookup");
        set_lk(16'd1, 20'd1, 44'h30, 12'h5); set_fill(16'd1, 20'd1, 44'h30, 44'h99, 2'd2);
        go("R9 lookup sees pre-fill state");
        set_lk(16'd1, 20'd1, 44'h30, 12'h5); go("R9 filled entry now hits");
        // R10: global enable
        cfg_enable = 1'b0;
        set_lk(16'd1, 20'd1, 44'h30, 12'h5); go("R10 disabled lookup misses");
        cfg_enable = 1'b1;
        // R5: zero limit
        cfg_limit = 5'd0;
        set_fill(16'd3, 20'd3, 44'h40, 44'h41, 2'd3); go("R5 fill with zero limit");
        set_lk(16'd3, 20'd3, 44'h40, 12'h0); go("R5 nothing stored");
        // R6/R7: limit 3, current count 2 (0x10 invalidated, 0x30)
        cfg_limit = 5'd3;
        set_fill(16'd1, 20'd1, 44'h30, 44'hAA, 2'd1); go("R7 refill in place");
        set_fill(16'd4, 20'd4, 44'h50, 44'h51, 2'd3); go("R7 third slot");
        set_lk(16'd1, 20'd1, 44'h30, 12'h7); go("R7 refilled value");
        set_lk(16'd4, 20'd4, 44'h50, 12'h7); go("R7 other entry kept");
        set_fill(16'd5, 20'd5, 44'h60, 44'h61, 2'd2); go("R6 fill at limit");
        set_lk(16'd4, 20'd4, 44'h50, 12'h7); go("R6 old entries dropped");
        set_lk(16'd5, 20'd5, 44'h60, 12'h7); go("R6 new entry present");
        // R8: invalidate modes
        cfg_limit = 5'd16;
        set_fill(16'd1, 20'd1, 44'h1, 44'h101, 2'd3); go("R8 setup");
        set_fill(16'd1, 20'd2, 44'h2, 44'h102, 2'd3); go("R8 setup");
        set_fill(16'd2, 20'd1, 44'h3, 44'h103, 2'd3); go("R8 setup");
        set_inv(2'd2, 16'd1, 20'd1, 44'h0); go("R8 gscid+pscid invalidate");
        set_lk(16'd1, 20'd1, 44'h1, 12'h0); go("R8 mode 2 cleared match");
        set_lk(16'd1, 20'd2, 44'h2, 12'h0); go("R8 mode 2 kept other pscid");
        set_inv(2'd1, 16'd2, 20'd9, 44'h0); go("R8 gscid invalidate");
        set_lk(16'd2, 20'd1, 44'h3, 12'h0); go("R8 mode 1 cleared");
        set_inv(2'd0, 16'd0, 20'd0, 44'h0); go("R8 invalidate all");
        set_lk(16'd1, 20'd2, 44'h2, 12'h0); go("R8 mode 0 cleared");
        // random phase
        for (int c = 0; c < 3000; c++) begin
            if (c % 250 == 0) begin
                case ($urandom_range(0, 4))
                    0: cfg_limit = 5'd0;
                    1: cfg_limit = 5'd2;
                    2: cfg_limit = 5'd5;
                    3: cfg_limit = 5'd16;
                    default: cfg_limit = 5'd20;
                endcase
            end
            cfg_enable = ($urandom_range(0, 19) != 0);
            if ($urandom_range(0, 9) < 6)
                set_lk(16'($urandom_range(1, 2)), 20'($urandom_range(1, 3)),
                       44'($urandom_range(0, 7)), 12'($urandom));
            if ($urandom_range(0, 9) < 4) begin
                logic [43:0] v;
                v = 44'($urandom_range(0, 7));
                set_fill(16'($urandom_range(1, 2)), 20'($urandom_range(1, 3)), v,
                         ($urandom_range(0, 7) == 0) ? v : 44'($urandom), 2'($urandom_range(1, 3)));
                fl_fault    = ($urandom_range(0, 9) == 0);
                fl_msi_trap = ($urandom_range(0, 9) == 0);
                fl_cache_en = ($urandom_range(0, 9) != 0);
            end
            if ($urandom_range(0, 9) == 0)
                set_inv(2'($urandom_range(0, 3)), 16'($urandom_range(1, 2)),
                        20'($urandom_range(1, 3)), 44'($urandom_range(0, 7)));
            go("R2 random mix");
        end
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule